// File: doc/BRIEF.md
# Programmable-Increment Time-of-Day Counter

This block keeps a free-running 64-bit time value for timestamping packets. An increment-control word sets how the count advances. Every P reference-clock cycles, the block adds a 24-bit increment I to the count. The increment is normally pre-scaled by a left shift, so the low bits of the count hold fractions of a nanosecond and the upper bits hold whole nanoseconds. A small P together with a heavily scaled I lets software correct the frequency in fine steps. The count wraps modulo 2^64 and never saturates.

Software uses a 32-bit register port to reach the counter, as a low word and a high word.
- Reading the low word also freezes the high word in a shadow copy, so the two reads of a pair always belong together.
- Writing the low word only stages that word. The whole 64-bit value is loaded when the high word is written.

A separate one-shot input takes a signed correction. The correction is folded into the next increment.

Top module: `tod_counter`

## Requirements
- R1: After reset, `time_now` is 0, the increment-control word is 0 (counting disabled) and `bus_rdata` is 0.
- R2: The increment-control word is written and read at address 2. Bits 31:24 are the period P and bits 23:0 are the increment I. When P is not 0, `time_now` grows by I exactly once every P clock cycles and changes at no other time, unless a load occurs.
- R3: While P is 0, `time_now` holds its value. Only a load can change it.
- R4: A read completes one cycle later on `bus_rdata`, and `bus_rdata` keeps its value between reads.
  - A read of address 0 returns the low 32 bits of the count and copies the high 32 bits into a shadow.
  - A read of address 1 returns the shadow, even if the live high word has moved on since.
- R5: A write to address 0 only stages the low word and leaves `time_now` unchanged. A write to address 1 loads {written word, staged low word} into the count on the next edge. The same write restarts the prescaler, so the first increment after the load comes P cycles later.
- R6: A write to address 2 that changes P restarts the prescaler at that edge, and that edge adds no increment. A write that keeps P but changes I leaves the prescaler phase untouched.
- R7: The count wraps modulo 2^64. An increment past all-ones continues from the low values.
- R8: A pulse on `adj_valid` captures `adj_delta` as a signed two's-complement value and adds it to the count together with the next increment.
  - Several pulses before that increment accumulate.
  - A pulse in the same cycle as an increment waits for the following one.
- R9: Address 3 reads as 0. A write to address 3 changes neither the count nor the control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 low word, 1 high word, 2 increment control, 3 unused |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| adj_valid | input | 1 | One-shot adjust strobe |
| adj_delta | input | 32 | Signed adjust amount |
| time_now | output | 64 | Current count |

## Verification
The counting function is driven with the four settings that match common reference clocks (periods 1 and 3 with large scaled increments). These show that the prescaler spacing and the full 24-bit increment width are right. Random periods, increments and start values follow, some of them close to all-ones, to separate a correct modulo-2^64 carry from a saturating or truncating one.

Directed sequences then cover the following:
- Period-change and same-period control writes are issued mid-count; the cycle of the next increment shows whether the prescaler restarted.
- Reads are split across a low-word rollover, to tell a shadowed high word from a live one.
- Adjust pulses arrive before an increment, twice before one increment, on the increment cycle itself and with a negative sign, which separates capture timing, accumulation and sign extension.

// File: rtl/tod_pkg.sv
package tod_pkg;
  // Register selector values decoded from the 2-bit address.
  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } tod_sel_e;
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] period,
  input  logic          restart,
  output logic          evt,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] cnt_q;
  logic          last;

  // Final tick of the current period; a zero period never reaches it.
  assign last  = (period != '0) && (cnt_q == period - ONE);
  assign evt   = last && !restart;
  assign phase = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart || last || (period == '0)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end
endmodule

// File: rtl/tod_regif.sv
module tod_regif
  import tod_pkg::*;
#(
  parameter int WW = 32,
  parameter int PW = 8,
  parameter int IW = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic            rd,
  input  logic [1:0]      addr,
  input  logic [WW-1:0]   wdata,
  input  logic [2*WW-1:0] time_in,
  output logic [WW-1:0]   rdata,
  output logic [WW-1:0]   lo_buf,
  output logic [PW+IW-1:0] ctrl_word,
  output logic [PW-1:0]   period,
  output logic [IW-1:0]   incval,
  output logic            load,
  output logic            restart
);
  localparam int CW = PW + IW;

  tod_sel_e      sel;
  logic [CW-1:0] ctrl_q;
  logic [WW-1:0] shadow_q;
  logic [WW-1:0] rdata_q;
  logic [WW-1:0] lo_q;
  logic          per_chg;

  assign sel       = tod_sel_e'(addr);
  assign period    = ctrl_q[CW-1:IW];
  assign incval    = ctrl_q[IW-1:0];
  assign ctrl_word = ctrl_q;
  assign lo_buf    = lo_q;
  assign rdata     = rdata_q;

  assign load    = wr && (sel == SEL_HI);
  assign per_chg = wr && (sel == SEL_CTRL) && (wdata[CW-1:IW] != ctrl_q[CW-1:IW]);
  assign restart = load || per_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      lo_q     <= '0;
      shadow_q <= '0;
      rdata_q  <= '0;
    end else begin
      if (wr) begin
        case (sel)
          SEL_LO:   lo_q   <= wdata;
          SEL_CTRL: ctrl_q <= wdata[CW-1:0];
          default:  ;
        endcase
      end
      if (rd) begin
        case (sel)
          SEL_LO: begin
            rdata_q  <= time_in[WW-1:0];
            shadow_q <= time_in[2*WW-1:WW];
          end
          SEL_HI:   rdata_q <= shadow_q;
          SEL_CTRL: rdata_q <= WW'(ctrl_q);
          default:  rdata_q <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int WW  = 32,
  parameter int PW  = 8,
  parameter int IW  = 24,
  parameter int AJW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [WW-1:0]     bus_wdata,
  output logic [WW-1:0]     bus_rdata,
  input  logic              adj_valid,
  input  logic [AJW-1:0]    adj_delta,
  output logic [2*WW-1:0]   time_now
);
  localparam int TW = 2 * WW;

  logic [TW-1:0]    time_q;
  logic [TW-1:0]    pend_q;
  logic [TW-1:0]    adj_ext;
  logic [TW-1:0]    inc_ext;
  logic             evt;
  logic             load;
  logic             restart;
  logic [PW-1:0]    period;
  logic [PW-1:0]    phase;
  logic [IW-1:0]    incval;
  logic [WW-1:0]    lo_buf;
  logic [PW+IW-1:0] ctrl_word;

  tod_regif #(.WW(WW), .PW(PW), .IW(IW)) u_regif (
    .clk       (clk),
    .rst       (rst),
    .wr        (bus_wr),
    .rd        (bus_rd),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .time_in   (time_q),
    .rdata     (bus_rdata),
    .lo_buf    (lo_buf),
    .ctrl_word (ctrl_word),
    .period    (period),
    .incval    (incval),
    .load      (load),
    .restart   (restart)
  );

  tod_prescaler #(.PW(PW)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .period  (period),
    .restart (restart),
    .evt     (evt),
    .phase   (phase)
  );

  assign adj_ext  = {{(TW-AJW){adj_delta[AJW-1]}}, adj_delta};
  assign inc_ext  = {{(TW-IW){1'b0}}, incval};
  assign time_now = time_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q <= '0;
      pend_q <= '0;
    end else begin
      if (load) begin
        time_q <= {bus_wdata, lo_buf};
      end else if (evt) begin
        time_q <= time_q + inc_ext + pend_q;
      end
      // Pending correction: drained by an increment, a pulse in that cycle waits.
      if (evt) begin
        pend_q <= adj_valid ? adj_ext : '0;
      end else if (adj_valid) begin
        pend_q <= pend_q + adj_ext;
      end
    end
  end
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter int WW = 32,
  parameter int PW = 8,
  parameter int IW = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_addr,
  input logic [WW-1:0]     bus_wdata,
  input logic [WW-1:0]     bus_rdata,
  input logic [2*WW-1:0]   time_now,
  input logic              evt,
  input logic              load,
  input logic              restart,
  input logic [PW-1:0]     period,
  input logic [PW-1:0]     phase,
  input logic [WW-1:0]     lo_buf,
  input logic [PW+IW-1:0]  ctrl_word
);
  assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (!evt && !load) |=> (time_now == $past(time_now)));

  assert_idle_R3: assert property (@(posedge clk) disable iff (rst)
    ((period == '0) && !load) |=> (time_now == $past(time_now)));

  assert_snap_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == 2'd0)) |=> (bus_rdata == $past(time_now[WW-1:0])));

  assert_load_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == 2'd1)) |=> (time_now == {$past(bus_wdata), $past(lo_buf)}));

  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    restart |=> (phase == '0));

  assert_ctrlrd_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == 2'd2)) |=> (bus_rdata == WW'($past(ctrl_word))));

  assert_none_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == 2'd3)) |=> (bus_rdata == '0));

  assert_nowr_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == 2'd3)) |=> (ctrl_word == $past(ctrl_word)));
endmodule

bind tod_counter tod_counter_chk #(.WW(WW), .PW(PW), .IW(IW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .time_now  (time_now),
  .evt       (evt),
  .load      (load),
  .restart   (restart),
  .period    (period),
  .phase     (phase),
  .lo_buf    (lo_buf),
  .ctrl_word (ctrl_word)
);

// File: tb/sim_tod_counter.sv
module sim_tod_counter;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 32, PW = 8, IW = 24, AJW = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        adj_valid = 1'b0;
  logic [31:0] adj_delta = '0;
  logic [63:0] time_now;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_counter #(.WW(WW), .PW(PW), .IW(IW), .AJW(AJW)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adj_valid(adj_valid),
    .adj_delta(adj_delta), .time_now(time_now)
  );

  task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All tasks are entered at a falling edge and return at a falling edge.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic load64(input logic [63:0] v);
    wr(2'd0, v[31:0]);
    wr(2'd1, v[63:32]);
  endtask

  task automatic setctrl(input int p, input logic [23:0] inc);
    wr(2'd2, {p[7:0], inc});
  endtask

  function automatic logic [63:0] model(input logic [63:0] s, input logic [23:0] inc,
                                        input int p, input int k);
    return s + 64'(k / p) * {40'd0, inc};
  endfunction

  task automatic run_seq(input string req, input logic [63:0] s, input int p,
                         input logic [23:0] inc, input int ncyc);
    setctrl(p, inc);
    load64(s);
    chk64(req, time_now, s);
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      chk64(req, time_now, model(s, inc, p, k));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] snap;
    logic [63:0] base;
    int unsigned seed_sink;
    int ref_p [4];
    int ref_i [4];
    ref_p = '{1, 3, 1, 3};
    ref_i = '{40 << 18, 125 << 14, 26 << 19, 125 << 17};
    seed_sink = $urandom(32'd20240611);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk64("R1 time", time_now, 64'd0);
    chk64("R1 rdata", {32'd0, bus_rdata}, 64'd0);
    rd(2'd2, d);
    chk64("R1 ctrl", {32'd0, d}, 64'd0);
    repeat (4) @(negedge clk);
    chk64("R1 idle", time_now, 64'd0);

    // R2 control readback and field layout
    setctrl(3, 24'h123456);
    rd(2'd2, d);
    chk64("R2 ctrl readback", {32'd0, d}, 64'h0312_3456);

    // R2 reference-clock settings
    for (int i = 0; i < 4; i++)
      run_seq("R2 ref", 64'h0000_0100_0000_0000, ref_p[i], ref_i[i][23:0], 12);

    // R2 / R7 random patterns, some near all-ones
    for (int t = 0; t < 10; t++) begin
      base = {$urandom(), $urandom()};
      if (t % 3 == 0) base = 64'hFFFF_FFFF_FF00_0000 | base[23:0];
      run_seq("R2 random", base, int'($urandom_range(1, 7)), 24'($urandom()), 15);
    end

    // R7 wrap through all-ones
    run_seq("R7 wrap", 64'hFFFF_FFFF_FFFF_FFF0, 1, 24'd7, 5);
    chk64("R7 wrapped value", time_now, 64'h0000_0000_0000_0013);

    // R3 period zero holds
    setctrl(0, 24'd100);
    load64(64'h1234_5678_9ABC_DEF0);
    repeat (20) @(negedge clk);
    chk64("R3 hold", time_now, 64'h1234_5678_9ABC_DEF0);

    // R5 staged low write, load on high write, prescaler restart
    setctrl(2, 24'd5);
    load64(64'd1000);                 // k=0
    @(negedge clk);                   // k=1
    wr(2'd0, 32'hDEAD_0000);          // k=2
    chk64("R5 low write staged", time_now, 64'd1005);
    @(negedge clk);                   // k=3
    chk64("R5 low write staged", time_now, 64'd1005);
    wr(2'd1, 32'h0000_0007);          // j=0
    chk64("R5 load", time_now, 64'h0000_0007_DEAD_0000);
    @(negedge clk);
    chk64("R5 restart", time_now, 64'h0000_0007_DEAD_0000);
    @(negedge clk);
    chk64("R5 first increment", time_now, 64'h0000_0007_DEAD_0005);

    // R4 coherent split read across a low-word rollover
    setctrl(1, 24'd16);
    load64(64'h0000_0004_FFFF_FF00);
    snap = time_now;
    rd(2'd0, d);
    chk64("R4 low", {32'd0, d}, {32'd0, snap[31:0]});
    repeat (30) @(negedge clk);
    rd(2'd1, d);
    chk64("R4 shadow high", {32'd0, d}, {32'd0, snap[63:32]});
    repeat (3) @(negedge clk);
    chk64("R4 rdata held", {32'd0, bus_rdata}, {32'd0, snap[63:32]});
    snap = time_now;
    rd(2'd0, d);
    rd(2'd1, d);
    chk64("R4 second pair high", {32'd0, d}, {32'd0, snap[63:32]});

    // R6 period change restarts the prescaler
    setctrl(4, 24'd1);
    load64(64'd0);                    // k=0
    @(negedge clk);                   // k=1
    setctrl(3, 24'd1);                // k=2
    @(negedge clk);                   // k=3
    @(negedge clk);                   // k=4
    chk64("R6 restart no early step", time_now, 64'd0);
    @(negedge clk);                   // k=5
    chk64("R6 restart step", time_now, 64'd1);
    repeat (3) @(negedge clk);        // k=8
    chk64("R6 restart second step", time_now, 64'd2);

    // R6 same period keeps the phase, new increment applies
    setctrl(4, 24'd1);
    load64(64'd0);                    // k=0
    @(negedge clk);                   // k=1
    setctrl(4, 24'd2);                // k=2
    @(negedge clk);                   // k=3
    chk64("R6 keep phase", time_now, 64'd0);
    @(negedge clk);                   // k=4
    chk64("R6 keep phase step", time_now, 64'd2);

    // R8 signed adjust
    setctrl(4, 24'd10);
    load64(64'd1000);                 // k=0
    @(negedge clk);                   // k=1
    adj_valid = 1'b1; adj_delta = -32'sd3;
    @(negedge clk);                   // k=2
    adj_valid = 1'b0;
    @(negedge clk);                   // k=3
    chk64("R8 not early", time_now, 64'd1000);
    @(negedge clk);                   // k=4
    chk64("R8 negative adjust", time_now, 64'd1007);
    repeat (4) @(negedge clk);        // k=8
    chk64("R8 one shot", time_now, 64'd1017);
    adj_valid = 1'b1; adj_delta = 32'd5;
    @(negedge clk);                   // k=9
    adj_delta = 32'd7;
    @(negedge clk);                   // k=10
    adj_valid = 1'b0;
    repeat (2) @(negedge clk);        // k=12
    chk64("R8 accumulate", time_now, 64'd1039);
    repeat (3) @(negedge clk);        // k=15
    adj_valid = 1'b1; adj_delta = 32'd100;
    @(negedge clk);                   // k=16
    adj_valid = 1'b0;
    chk64("R8 event-cycle pulse waits", time_now, 64'd1049);
    repeat (4) @(negedge clk);        // k=20
    chk64("R8 deferred apply", time_now, 64'd1159);
    @(negedge clk);                   // k=21
    adj_valid = 1'b1; adj_delta = -32'sd2000;
    @(negedge clk);                   // k=22
    adj_valid = 1'b0;
    repeat (2) @(negedge clk);        // k=24
    chk64("R8 sign extension wrap", time_now, 64'd1159 + 64'd10 - 64'd2000);

    // R9 unused address
    setctrl(0, 24'd5);
    load64(64'd77);
    wr(2'd3, 32'hFFFF_FFFF);
    chk64("R9 write ignored time", time_now, 64'd77);
    rd(2'd2, d);
    chk64("R9 write ignored ctrl", {32'd0, d}, 64'h0000_0005);
    rd(2'd3, d);
    chk64("R9 reads zero", {32'd0, d}, 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule